// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator with Bit-20 Gate

This block turns a segment value and an offset value into a physical address the way a real-mode processor does. The segment is shifted left by four bit positions and the zero-extended offset is added to it. The adder result is one bit wider than the 20-bit real-mode space. That top bit is the carry into bit 20. It passes through a gate before it reaches the output.

The gate has three controls. A mode input picks a 20-line machine, where the top bit never exists and addresses wrap at 1 MB, or a 21-line machine, where the carry may appear. An active-low mask pin forces the top bit low. An internal gate state can also close the gate. An external controller updates that state through simple message cycles, and the state is closed out of reset. The output address is registered and carries a valid strobe one cycle behind the request.

Top module: `realmode_addr_gen`

## Requirements
- R1: The low output bits (bits 19..0 at default parameters) equal the low bits of segment*16 + offset for every input pair, and no mask, mode or gate setting ever changes them.
- R2: With `wideMode` low, the top output bit (bit 20 at default parameters) is 0 for every input.
- R3: With `wideMode` high, `maskPinN` high and the gate open, the top output bit equals the carry out of the low bits of segment*16 + offset.
- R4: With `maskPinN` low in the request cycle, the top output bit is 0 whatever the sum.
- R5: While and right after reset, `gateOpen` is 0, `physValid` is 0 and `physAddr` is 0, so bit 20 is masked until a message opens the gate.
- R6: A message cycle (`gateMsgValid` high) sets the gate state to `gateMsgOpen` (1 opens, 0 closes). `gateOpen` shows the new state from the next cycle. A request in the message cycle still uses the old state, and a request in the following cycle uses the new state. When `gateMsgValid` is low, the payload has no effect.
- R7: The effective mask is the OR of the pin and the closed gate state, so a closed gate alone forces the top bit to 0 even with `maskPinN` high.
- R8: `physValid` is high exactly one cycle after a cycle with `addrValid` high. After a cycle with `addrValid` low, `physAddr` keeps its previous value.
- R9: Segment 0xFFFF with offset 0xFFFF gives 0x10FFEF with the gate open (wide mode, pin high) and 0x00FFEF with the gate closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addrValid | input | 1 | Address request strobe |
| segIn | input | SEG_W (16) | Segment value |
| offIn | input | OFF_W (16) | Offset value |
| wideMode | input | 1 | 1: 21-line behaviour, 0: 20-line wrap |
| maskPinN | input | 1 | Active-low direct mask of the top address bit |
| gateMsgValid | input | 1 | Gate-control message strobe |
| gateMsgOpen | input | 1 | Message payload: 1 opens, 0 closes the gate |
| physAddr | output | ADDR_W (21) | Registered physical address |
| physValid | output | 1 | Address-valid strobe, one cycle after the request |
| gateOpen | output | 1 | Current gate state (1 = open) |

## Verification
The bench builds two instances. The first uses the default 16-bit segment and offset widths, and it runs the directed corner cases: the 0xFFFF:0xFFFF limit, the reset state, and the exact timing of a message against a request in the same cycle. The second uses 6-bit segment and offset widths with the same 4-bit shift. That gives an 11-bit address whose top bit still receives real carries. At that size every segment and offset pair can be swept under each of the four gate configurations: open, narrow mode, pin mask and closed state. Every carry and wrap case is therefore compared against arithmetic done in the bench.

// File: rtl/realmode_addr_pkg.sv
package realmode_addr_pkg;

  // Strobes passed from the control module to the datapath
  typedef struct packed {
    logic load;      // capture a new address this cycle
    logic clearTop;  // force the top address bit to zero
  } addr_ctrl_t;

endpackage

// File: rtl/realmode_addr_ctrl.sv
module realmode_addr_ctrl
  import realmode_addr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       addrValid,
  input  logic       wideMode,
  input  logic       maskPinN,
  input  logic       gateMsgValid,
  input  logic       gateMsgOpen,
  output addr_ctrl_t ctrl,
  output logic       gateOpen
);

  logic gateState;

  // Gate state: closed at reset, rewritten only by message cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateState <= 1'b0;
    end else if (gateMsgValid) begin
      gateState <= gateMsgOpen;
    end
  end

  // A request uses the gate state held before any message in the same cycle
  always_comb begin
    ctrl.load     = addrValid;
    ctrl.clearTop = !wideMode || !maskPinN || !gateState;
  end

  assign gateOpen = gateState;

  assert_gate_closed_after_reset_R5: assert property (
    @(posedge clk) !rstN |=> !gateOpen
  ) else $error("gate not closed after reset");

  assert_msg_updates_gate_R6: assert property (
    @(posedge clk) disable iff (!rstN)
    gateMsgValid |=> (gateOpen == $past(gateMsgOpen))
  ) else $error("message did not set gate state");

  assert_gate_holds_without_msg_R6: assert property (
    @(posedge clk) disable iff (!rstN)
    !gateMsgValid |=> $stable(gateOpen)
  ) else $error("gate changed without a message");

endmodule

// File: rtl/realmode_addr_datapath.sv
module realmode_addr_datapath
  import realmode_addr_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = ((SEG_W + SHIFT) > OFF_W ? (SEG_W + SHIFT) : OFF_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  addr_ctrl_t        ctrl,
  input  logic [SEG_W-1:0]  segIn,
  input  logic [OFF_W-1:0]  offIn,
  output logic [ADDR_W-1:0] physAddr,
  output logic              physValid
);

  localparam int TOP     = ADDR_W - 1;
  localparam int SEG_PAD = ADDR_W - SEG_W - SHIFT;
  localparam int OFF_PAD = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] segTerm;
  logic [ADDR_W-1:0] offTerm;
  logic [ADDR_W-1:0] sum;
  logic [ADDR_W-1:0] gated;

  // The adder is one bit wider than the wrap boundary, so the carry lands in TOP
  assign segTerm = {{SEG_PAD{1'b0}}, segIn, {SHIFT{1'b0}}};
  assign offTerm = {{OFF_PAD{1'b0}}, offIn};
  assign sum     = segTerm + offTerm;

  // Only the top bit goes through the gate
  assign gated = {sum[TOP] & !ctrl.clearTop, sum[TOP-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      physAddr  <= '0;
      physValid <= 1'b0;
    end else begin
      physValid <= ctrl.load;
      if (ctrl.load) begin
        physAddr <= gated;
      end
    end
  end

  assert_hold_when_idle_R8: assert property (
    @(posedge clk) disable iff (!rstN)
    !ctrl.load |=> $stable(physAddr)
  ) else $error("address changed without a load");

  assert_cleared_top_R7: assert property (
    @(posedge clk) disable iff (!rstN)
    (ctrl.load && ctrl.clearTop) |=> !physAddr[TOP]
  ) else $error("top bit set while cleared");

endmodule

// File: rtl/realmode_addr_gen.sv
module realmode_addr_gen
  import realmode_addr_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = ((SEG_W + SHIFT) > OFF_W ? (SEG_W + SHIFT) : OFF_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrValid,
  input  logic [SEG_W-1:0]  segIn,
  input  logic [OFF_W-1:0]  offIn,
  input  logic              wideMode,
  input  logic              maskPinN,
  input  logic              gateMsgValid,
  input  logic              gateMsgOpen,
  output logic [ADDR_W-1:0] physAddr,
  output logic              physValid,
  output logic              gateOpen
);

  localparam int TOP = ADDR_W - 1;

  addr_ctrl_t ctrl;

  realmode_addr_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .addrValid    (addrValid),
    .wideMode     (wideMode),
    .maskPinN     (maskPinN),
    .gateMsgValid (gateMsgValid),
    .gateMsgOpen  (gateMsgOpen),
    .ctrl         (ctrl),
    .gateOpen     (gateOpen)
  );

  realmode_addr_datapath #(
    .SEG_W  (SEG_W),
    .OFF_W  (OFF_W),
    .SHIFT  (SHIFT),
    .ADDR_W (ADDR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .segIn     (segIn),
    .offIn     (offIn),
    .physAddr  (physAddr),
    .physValid (physValid)
  );

  assert_valid_latency_R8: assert property (
    @(posedge clk) disable iff (!rstN)
    addrValid |=> physValid
  ) else $error("valid strobe missing");

  assert_no_valid_without_req_R8: assert property (
    @(posedge clk) disable iff (!rstN)
    !addrValid |=> !physValid
  ) else $error("spurious valid strobe");

  assert_narrow_wraps_R2: assert property (
    @(posedge clk) disable iff (!rstN)
    (addrValid && !wideMode) |=> !physAddr[TOP]
  ) else $error("top bit set in narrow mode");

  assert_pin_masks_R4: assert property (
    @(posedge clk) disable iff (!rstN)
    (addrValid && !maskPinN) |=> !physAddr[TOP]
  ) else $error("top bit set under pin mask");

  assert_closed_gate_masks_R7: assert property (
    @(posedge clk) disable iff (!rstN)
    (addrValid && !gateOpen) |=> !physAddr[TOP]
  ) else $error("top bit set with gate closed");

endmodule

// File: tb/realmode_addr_gen_bench.sv
module realmode_addr_gen_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        addrValid = 1'b0;
  logic [15:0] segL = '0;
  logic [15:0] offL = '0;
  logic [5:0]  segS = '0;
  logic [5:0]  offS = '0;
  logic        wideMode = 1'b1;
  logic        maskPinN = 1'b1;
  logic        gateMsgValid = 1'b0;
  logic        gateMsgOpen = 1'b0;

  logic [20:0] physAddrL;
  logic        physValidL;
  logic        gateOpenL;
  logic [10:0] physAddrS;
  logic        physValidS;
  logic        gateOpenS;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  realmode_addr_gen u_realmode_addr_gen (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .segIn(segL), .offIn(offL),
    .wideMode(wideMode), .maskPinN(maskPinN), .gateMsgValid(gateMsgValid),
    .gateMsgOpen(gateMsgOpen), .physAddr(physAddrL), .physValid(physValidL),
    .gateOpen(gateOpenL)
  );

  realmode_addr_gen #(.SEG_W(6), .OFF_W(6), .SHIFT(4)) u_realmode_addr_gen_small (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .segIn(segS), .offIn(offS),
    .wideMode(wideMode), .maskPinN(maskPinN), .gateMsgValid(gateMsgValid),
    .gateMsgOpen(gateMsgOpen), .physAddr(physAddrS), .physValid(physValidS),
    .gateOpen(gateOpenS)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, got, exp);
    end
  endtask

  // Drive one cycle of stimulus at a falling edge; results are visible at the next one
  task automatic step();
    @(negedge clk);
  endtask

  // Gate message with no address request
  task automatic sendMsg(input logic open);
    gateMsgValid = 1'b1;
    gateMsgOpen  = open;
    addrValid    = 1'b0;
    step();
    gateMsgValid = 1'b0;
  endtask

  // Exhaustive sweep of the small instance under the current settings
  task automatic sweep(input string tag, input logic topAllowed);
    for (int s = 0; s < 64; s++) begin
      for (int o = 0; o < 64; o++) begin
        int sum;
        int exp;
        segS = 6'(s);
        offS = 6'(o);
        addrValid = 1'b1;
        step();
        sum = s * 16 + o;
        exp = (sum % 1024) + ((topAllowed && sum >= 1024) ? 1024 : 0);
        check(tag, {21'b0, physAddrS}, exp);
      end
    end
    addrValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R5: reset state
    repeat (3) step();
    check("R5 physAddr in reset", {11'b0, physAddrL}, 0);
    check("R5 physValid in reset", {31'b0, physValidL}, 0);
    check("R5 gateOpen in reset", {31'b0, gateOpenL}, 0);
    rstN = 1'b1;
    step();
    check("R5 gateOpen after reset", {31'b0, gateOpenL}, 0);

    // R9/R5: limit address with gate closed after reset
    segL = 16'hFFFF; offL = 16'hFFFF; addrValid = 1'b1;
    step();
    check("R9 limit gate closed", {11'b0, physAddrL}, 32'h00FFEF);
    check("R8 valid after request", {31'b0, physValidL}, 1);

    // R6: message and request in the same cycle; request sees the old state
    gateMsgValid = 1'b1; gateMsgOpen = 1'b1;
    step();
    gateMsgValid = 1'b0;
    check("R6 same-cycle request uses old state", {11'b0, physAddrL}, 32'h00FFEF);
    check("R6 gateOpen after open msg", {31'b0, gateOpenL}, 1);
    step();
    check("R9 limit gate open", {11'b0, physAddrL}, 32'h10FFEF);
    check("R3 carry reaches top bit", {31'b0, physAddrL[20]}, 1);

    // R8: idle cycle holds address, drops valid
    addrValid = 1'b0; segL = 16'h1234; offL = 16'h0001;
    step();
    check("R8 no valid when idle", {31'b0, physValidL}, 0);
    check("R8 address held when idle", {11'b0, physAddrL}, 32'h10FFEF);

    // R4: pin mask
    maskPinN = 1'b0; segL = 16'hFFFF; offL = 16'hFFFF; addrValid = 1'b1;
    step();
    check("R4 pin forces top low", {11'b0, physAddrL}, 32'h00FFEF);
    check("R4 pin leaves gate state", {31'b0, gateOpenL}, 1);
    maskPinN = 1'b1;

    // R2: narrow mode with the gate open
    wideMode = 1'b0;
    step();
    check("R2 narrow wraps", {11'b0, physAddrL}, 32'h00FFEF);
    wideMode = 1'b1;

    // R1: plain sums without carry
    segL = 16'h1234; offL = 16'h5678;
    step();
    check("R1 sum 1234:5678", {11'b0, physAddrL}, 32'h179B8);
    addrValid = 1'b0;

    // R1/R3: exhaustive small sweep with gate open
    sweep("R3 small sweep open", 1'b1);
    // R2: narrow mode
    wideMode = 1'b0;
    sweep("R2 small sweep narrow", 1'b0);
    wideMode = 1'b1;
    // R4: pin asserted
    maskPinN = 1'b0;
    sweep("R4 small sweep pin", 1'b0);
    maskPinN = 1'b1;

    // R6: payload ignored without a strobe
    gateMsgValid = 1'b0; gateMsgOpen = 1'b0;
    step();
    check("R6 payload ignored without strobe", {31'b0, gateOpenS}, 1);
    // R6: close message
    sendMsg(1'b0);
    check("R6 gateOpen after close msg", {31'b0, gateOpenS}, 0);
    gateMsgOpen = 1'b1;
    step();
    check("R6 open payload ignored without strobe", {31'b0, gateOpenL}, 0);

    // R7: closed gate alone with pin high
    sweep("R7 small sweep closed", 1'b0);
    segL = 16'hFFFF; offL = 16'hFFFF; addrValid = 1'b1;
    step();
    check("R7 limit closed pin high", {11'b0, physAddrL}, 32'h00FFEF);
    addrValid = 1'b0;
    step();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule